// File: doc/BRIEF.md
# Battery Monitor Sleep Controller

This block decides when a battery-monitoring device may drop into its low-power sleep state and when it must come back out. Three things must hold together before the device sleeps. The most recent current sample must be below a programmable threshold. Both lines of the two-wire serial bus must have stayed low for a programmable number of ticks. A sleep-inhibit bit in the miscellaneous configuration word must be clear.

While the device is asleep, two independent tick-driven timers run. One asks for a voltage, temperature and self-discharge update. The other asks for a fresh current measurement. Each request is a single-cycle pulse. The device leaves sleep at once when either bus line rises, or when a current sample arrives that is not below the threshold. Leaving sleep clears both timers.

Current samples are a valid-only input stream. The block accepts a sample on every cycle in which `cur_valid_i` is high and never applies back-pressure, so there is no ready signal. All other pins are plain level or pulse control signals.

Top module: `batt_sleep_ctrl`

## Requirements
- R1: Sleep is entered only if the latest accepted current sample is strictly below `cur_thr_i`. Out of reset, no sample counts as low, and a sample equal to the threshold blocks entry.
- R2: Both bus lines, after two-flop synchronisation, must be low during `BUS_IDLE_TICKS` consecutive ticks before entry. Any high level on either line restarts that count from zero.
- R3: Entry is blocked while bit 4 of `misc_cfg_i` is 1. All other bits of `misc_cfg_i` have no effect.
- R4: While asleep, `vt_req_o` pulses high for one cycle on every `vt_period_i`-th tick counted from sleep entry. A period of 0 behaves like 1.
- R5: While asleep, `cur_req_o` pulses high for one cycle on every `ci_period_i`-th tick counted from sleep entry. A period of 0 behaves like 1. This timer runs independently of the R4 timer.
- R6: A rising edge on either bus line while asleep clears `asleep_o` within three clock cycles.
- R7: While asleep, an accepted current sample that is greater than or equal to `cur_thr_i` clears `asleep_o` on the next clock edge.
- R8: `vt_req_o` and `cur_req_o` never pulse while the block is awake.
- R9: Exiting sleep clears both wake timers, so every new sleep period starts with full intervals.
- R10: After reset, `asleep_o`, `vt_req_o` and `cur_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Single-cycle time-base tick |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line (asynchronous) |
| cur_valid_i | input | 1 | Current sample valid; always accepted |
| cur_mag_i | input | CUR_W | Current magnitude of the sample |
| cur_thr_i | input | CUR_W | Sleep current threshold |
| misc_cfg_i | input | CFG_W | Configuration word; bit 4 inhibits sleep |
| vt_period_i | input | PER_W | Voltage/temperature wake period, in ticks |
| ci_period_i | input | PER_W | Current-measurement wake period, in ticks |
| asleep_o | output | 1 | High while in the sleep state |
| vt_req_o | output | 1 | Voltage/temperature/self-discharge update request pulse |
| cur_req_o | output | 1 | Current-measurement request pulse |

## Verification
The main function is driven from a table of period pairs and tick counts. The table includes equal periods, one period much larger than the other, a period of 1, a period of 0, and tick counts that fall short of a full interval. The pulse counts therefore separate a shared timer from two independent ones, show whether a period of 0 is handled, and reveal off-by-one errors in the terminal count. Directed cases look at each entry condition on its own. These cover one tick short of the idle count, a short high pulse on a bus line partway through the idle count, a current sample exactly at the threshold, and the inhibit bit set versus a neighbouring bit set. Exit is tested through the data line, the clock line and the current input. The last case wakes the block partway through an interval and checks that the next sleep starts from zero.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } slp_state_e;

  // configuration bit that inhibits sleep entry
  localparam int CFG_NOSLEEP_BIT = 4;
  // number of wake timers
  localparam int N_TMR = 2;
endpackage

// File: rtl/bsc_bus_watch.sv
module bsc_bus_watch #(
  parameter int IDLE_TICKS = 16,
  localparam int CW = $clog2(IDLE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic rise_o,
  output logic idle_o
);
  logic [1:0]    scl_sync, sda_sync;
  logic          scl_q, sda_q;
  logic [CW-1:0] low_cnt;
  logic          any_high;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sync <= '0;
      sda_sync <= '0;
      scl_q    <= 1'b0;
      sda_q    <= 1'b0;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end
  end

  assign any_high = scl_sync[1] | sda_sync[1];
  assign rise_o   = (scl_sync[1] & ~scl_q) | (sda_sync[1] & ~sda_q);

  always_ff @(posedge clk) begin
    if (!rst_n)
      low_cnt <= '0;
    else if (any_high)
      low_cnt <= '0;
    else if (tick_i && low_cnt != CW'(IDLE_TICKS))
      low_cnt <= low_cnt + CW'(1);
  end

  assign idle_o = (low_cnt == CW'(IDLE_TICKS));

  AST_IDLE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(tick_i)); // R2
  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> $past(!any_high)); // R2
endmodule

// File: rtl/bsc_wake_timer.sv
module bsc_wake_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             pulse_o
);
  logic [PER_W-1:0] cnt;
  logic [PER_W:0]   nxt;
  logic             fire;

  assign nxt  = {1'b0, cnt} + (PER_W+1)'(1);
  assign fire = nxt >= {1'b0, period_i};

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      cnt     <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (tick_i) begin
        if (fire) begin
          cnt     <= '0;
          pulse_o <= 1'b1;
        end else begin
          cnt <= nxt[PER_W-1:0];
        end
      end
    end
  end

  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(run_i && tick_i)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o || $past(tick_i)); // R5
  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt == '0)); // R9
endmodule

// File: rtl/bsc_sleep_fsm.sv
module bsc_sleep_fsm
  import bsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_idle_i,
  input  logic bus_rise_i,
  input  logic cur_valid_i,
  input  logic cur_below_i,
  input  logic inhibit_i,
  output logic asleep_o,
  output logic run_o
);
  slp_state_e state;
  logic       cur_low;
  logic       exit_now;
  logic       enter_now;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur_low <= 1'b0;
    else if (cur_valid_i)
      cur_low <= cur_below_i;
  end

  assign exit_now  = (state == ST_ASLEEP) &&
                     (bus_rise_i || (cur_valid_i && !cur_below_i));
  assign enter_now = (state == ST_AWAKE) && bus_idle_i && cur_low && !inhibit_i;

  always_ff @(posedge clk) begin
    if (!rst_n)
      state <= ST_AWAKE;
    else if (enter_now)
      state <= ST_ASLEEP;
    else if (exit_now)
      state <= ST_AWAKE;
  end

  assign asleep_o = (state == ST_ASLEEP);
  assign run_o    = asleep_o && !exit_now;

  AST_ENTRY_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> $past(bus_idle_i && cur_low && !inhibit_i)); // R1
  AST_BUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_o && bus_rise_i) |=> !asleep_o); // R6
  AST_CUR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_o && cur_valid_i && !cur_below_i) |=> !asleep_o); // R7
  AST_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep_o && inhibit_i) |=> !asleep_o); // R3
endmodule

// File: rtl/batt_sleep_ctrl.sv
module batt_sleep_ctrl
  import bsc_pkg::*;
#(
  parameter int CUR_W          = 16,
  parameter int PER_W          = 16,
  parameter int CFG_W          = 16,
  parameter int BUS_IDLE_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             cur_valid_i,
  input  logic [CUR_W-1:0] cur_mag_i,
  input  logic [CUR_W-1:0] cur_thr_i,
  input  logic [CFG_W-1:0] misc_cfg_i,
  input  logic [PER_W-1:0] vt_period_i,
  input  logic [PER_W-1:0] ci_period_i,
  output logic             asleep_o,
  output logic             vt_req_o,
  output logic             cur_req_o
);
  logic                        bus_rise, bus_idle, run;
  logic                        cur_below;
  logic [N_TMR-1:0][PER_W-1:0] periods;
  logic [N_TMR-1:0]            pulses;
  logic                        unused_cfg;

  assign cur_below  = cur_mag_i < cur_thr_i;
  assign unused_cfg = ^{misc_cfg_i[CFG_W-1:CFG_NOSLEEP_BIT+1],
                        misc_cfg_i[CFG_NOSLEEP_BIT-1:0]};

  bsc_bus_watch #(.IDLE_TICKS(BUS_IDLE_TICKS)) u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .rise_o (bus_rise),
    .idle_o (bus_idle)
  );

  bsc_sleep_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_idle_i  (bus_idle),
    .bus_rise_i  (bus_rise),
    .cur_valid_i (cur_valid_i),
    .cur_below_i (cur_below),
    .inhibit_i   (misc_cfg_i[CFG_NOSLEEP_BIT]),
    .asleep_o    (asleep_o),
    .run_o       (run)
  );

  assign periods[0] = vt_period_i;
  assign periods[1] = ci_period_i;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    bsc_wake_timer #(.PER_W(PER_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run),
      .tick_i   (tick_i),
      .period_i (periods[g]),
      .pulse_o  (pulses[g])
    );
  end

  assign vt_req_o  = pulses[0];
  assign cur_req_o = pulses[1];

  AST_NO_AWAKE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (vt_req_o || cur_req_o) |-> $past(asleep_o)); // R8
endmodule

// File: tb/tb_batt_sleep_ctrl.sv
module tb_batt_sleep_ctrl;
  localparam int IDLE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, scl = 1'b0, sda = 1'b0, cvld = 1'b0;
  logic [15:0] cmag = '0, cthr = 16'd100, cfg = '0, vtp = 16'd3, cip = 16'd5;
  logic        asleep, vtr, cir;
  int          tests = 0, fails = 0;
  int          vt_seen = 0, ci_seen = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  batt_sleep_ctrl #(.BUS_IDLE_TICKS(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .scl_i(scl), .sda_i(sda),
    .cur_valid_i(cvld), .cur_mag_i(cmag), .cur_thr_i(cthr), .misc_cfg_i(cfg),
    .vt_period_i(vtp), .ci_period_i(cip), .asleep_o(asleep),
    .vt_req_o(vtr), .cur_req_o(cir)
  );

  always @(negedge clk) begin
    if (vtr) vt_seen++;
    if (cir) ci_seen++;
  end

  // vt period, ci period, ticks, expected vt pulses, expected ci pulses
  localparam int VEC[6][5] = '{
    '{3, 5, 15, 5, 3},
    '{1, 2,  7, 7, 3},
    '{4, 4,  3, 0, 0},
    '{0, 6,  6, 6, 1},
    '{7, 2, 10, 1, 5},
    '{2, 3, 12, 6, 4}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic sample(input int mag);
    @(negedge clk) begin cmag = 16'(mag); cvld = 1'b1; end
    @(negedge clk) cvld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic go_sleep();
    scl = 1'b0; sda = 1'b0;
    repeat (4) @(negedge clk);
    sample(10);
    tk(IDLE);
    repeat (3) @(negedge clk);
  endtask

  task automatic wake_scl();
    @(negedge clk) scl = 1'b1;
    repeat (5) @(negedge clk);
    scl = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R10 asleep at reset", int'(asleep), 0);
    chk("R10 requests at reset", int'(vtr | cir), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R4 / R5 pulse counts, R6 wake by clock line
    for (int v = 0; v < 6; v++) begin
      vtp = 16'(VEC[v][0]); cip = 16'(VEC[v][1]);
      go_sleep();
      chk("R1/R2 entry", int'(asleep), 1);
      vt_seen = 0; ci_seen = 0;
      tk(VEC[v][2]);
      chk("R4 vt pulses", vt_seen, VEC[v][3]);
      chk("R5 ci pulses", ci_seen, VEC[v][4]);
      wake_scl();
      chk("R6 clock-line wake", int'(asleep), 0);
    end

    // R8: ticks while awake give no requests
    vtp = 16'd1; cip = 16'd1; vt_seen = 0; ci_seen = 0;
    scl = 1'b1; tk(4); scl = 1'b0;
    chk("R8 no awake pulses", vt_seen + ci_seen, 0);

    // R2: one tick short stays awake
    repeat (4) @(negedge clk);
    sample(10);
    tk(IDLE - 1);
    repeat (3) @(negedge clk);
    chk("R2 one tick short", int'(asleep), 0);
    tk(1); repeat (3) @(negedge clk);
    chk("R2 full idle count", int'(asleep), 1);
    wake_scl();

    // R2: brief data-line high restarts the count
    tk(IDLE - 2);
    @(negedge clk) sda = 1'b1;
    repeat (3) @(negedge clk);
    sda = 1'b0;
    repeat (4) @(negedge clk);
    tk(IDLE - 2);
    repeat (3) @(negedge clk);
    chk("R2 count restarted", int'(asleep), 0);
    tk(2); repeat (3) @(negedge clk);
    chk("R2 entry after restart", int'(asleep), 1);

    // R6: wake via data line
    @(negedge clk) sda = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 data-line wake", int'(asleep), 0);
    sda = 1'b0;

    // R1: sample equal to threshold blocks entry
    repeat (4) @(negedge clk);
    sample(100);
    tk(IDLE + 2); repeat (3) @(negedge clk);
    chk("R1 equal blocks entry", int'(asleep), 0);

    // R3: inhibit bit blocks, a neighbour bit does not
    cfg = 16'h0010;
    go_sleep();
    chk("R3 bit4 inhibits", int'(asleep), 0);
    cfg = 16'hFFEF;
    scl = 1'b1; repeat (4) @(negedge clk);
    go_sleep();
    chk("R3 other bits ignored", int'(asleep), 1);
    cfg = 16'h0000;

    // R7: high current sample wakes next edge
    @(negedge clk) begin cmag = 16'd100; cvld = 1'b1; end
    @(negedge clk) cvld = 1'b0;
    chk("R7 current wake", int'(asleep), 0);

    // R9: timers restart after exit
    vtp = 16'd3; cip = 16'd3;
    scl = 1'b1; repeat (4) @(negedge clk);
    go_sleep();
    vt_seen = 0; ci_seen = 0;
    tk(2);
    wake_scl();
    go_sleep();
    tk(2);
    chk("R9 no carry-over", vt_seen + ci_seen, 0);
    tk(1);
    chk("R9 full period", vt_seen, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule